// File: doc/BRIEF.md
# Sound Generator Host Bus Interface

This block is the processor-facing side of a three-voice programmable sound generator. A host drives a three-wire bus-control code, two upper-address bits and an 8-bit data word. The block turns the control code into one of four cycle kinds: idle, pointer load, register store or register fetch. It keeps a 4-bit register pointer and a bank of sixteen 8-bit control registers. When a register fetch is under way, it returns the addressed register on a data bus. That bus is modelled as separate input, output and output-enable signals.

The sound datapath sees every register at all times through a flat bus. Storing to the envelope-shape register raises a one-cycle restart pulse for the envelope generator. Two 8-bit general-purpose ports take their output values from the last two registers. One control register sets the direction of each port, and a fetch from a port returns either its pins or its stored value. Tone, noise and envelope generation are outside this block. All bus inputs are sampled on the rising clock edge, and every output is registered.

Top module: `snd_bus_if`

## Requirements
- R1: A synchronous active-high `rst` clears all sixteen registers. It also sets the pointer to 0, deselects the block, and drives `data_oe` and `env_restart` low.
- R2: The control code {bdir,bc2,bc1} decodes as follows: 001, 100 and 111 are pointer load; 110 is register store; 011 is register fetch; 000, 010 and 101 are idle. An idle cycle changes no register and no output.
- R3: A pointer-load cycle with `hi_addr` = 2'b01 and `data_in[7:4]` = 4'b0000 loads `data_in[3:0]` into the pointer and selects the block.
- R4: A pointer-load cycle whose upper address does not match deselects the block and leaves the pointer unchanged. While the block is deselected, fetch cycles leave `data_oe` low and store cycles change nothing.
- R5: The pointer keeps its value through store, fetch and idle cycles until the next matching pointer-load cycle.
- R6: A store cycle while selected writes `data_in` into the pointed register. The new value appears on `reg_flat[8*i+7:8*i]` in the cycle after the edge.
- R7: Unimplemented bits are stored as 0 and read back as 0: bits 7..4 of registers 1, 3, 5 and 13, and bits 7..5 of registers 6, 8, 9 and 10.
- R8: After a fetch edge while selected, `data_oe` is 1 and `data_out` holds the addressed value for one cycle. `data_oe` falls after any non-fetch cycle. A fetch changes no register and raises no restart pulse.
- R9: `env_restart` is 1 for exactly the cycle after a selected store to register 13, and is 0 otherwise.
- R10: Register 7 bit 6 drives `porta_oe` and bit 7 drives `portb_oe`, where 1 means output. `porta_out` is register 14 and `portb_out` is register 15.
- R11: A fetch of register 14 (or 15) returns `porta_in` (or `portb_in`) as sampled at the fetch edge when that port's direction bit is 0, and the stored register when the bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bdir | input | 1 | Bus-control wire, most significant |
| bc2 | input | 1 | Bus-control wire, middle |
| bc1 | input | 1 | Bus-control wire, least significant |
| hi_addr | input | 2 | Upper address bits; 2'b01 matches |
| data_in | input | 8 | Data bus from host |
| data_out | output | 8 | Data bus to host |
| data_oe | output | 1 | Data bus output enable |
| reg_flat | output | 128 | All registers, register i at bits 8*i+7..8*i |
| env_restart | output | 1 | One-cycle envelope restart pulse |
| porta_in | input | 8 | Port A pin inputs |
| porta_out | output | 8 | Port A output values |
| porta_oe | output | 1 | Port A drive enable |
| portb_in | input | 8 | Port B pin inputs |
| portb_out | output | 8 | Port B output values |
| portb_oe | output | 1 | Port B drive enable |

## Verification
A wrong pointer or select state shows up at the next fetch: either `data_oe` stays low or the wrong value appears one cycle after the fetch edge. A later store also lands on the wrong slice of `reg_flat`, and this is visible one cycle after that store. Masking faults and port-direction faults show directly on `reg_flat` and on the port outputs one cycle after the store. The bench compares every output against a cycle-accurate model after every bus cycle, so a divergence is reported within one cycle of the cycle that caused it.

// File: rtl/snd_bus_pkg.sv
package snd_bus_pkg;
  localparam int REG_DW  = 8;
  localparam int REG_NUM = 16;
  localparam int PTR_W   = $clog2(REG_NUM);

  localparam int IOCTL_IDX = 7;
  localparam int ENV_IDX   = 13;
  localparam int PORTA_IDX = 14;
  localparam int PORTB_IDX = 15;
  localparam int DIR_A_BIT = 6;
  localparam int DIR_B_BIT = 7;

  typedef enum logic [1:0] {
    M_IDLE  = 2'd0,
    M_ADDR  = 2'd1,
    M_WRITE = 2'd2,
    M_READ  = 2'd3
  } bus_mode_e;

  function automatic bus_mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'b001, 3'b100, 3'b111: decode_mode = M_ADDR;
      3'b110:                 decode_mode = M_WRITE;
      3'b011:                 decode_mode = M_READ;
      default:                decode_mode = M_IDLE;
    endcase
  endfunction

  // implemented-bit mask per register slot
  function automatic logic [REG_DW-1:0] impl_mask(input int idx);
    case (idx)
      1, 3, 5, 13:  impl_mask = REG_DW'(8'h0F);
      6, 8, 9, 10:  impl_mask = REG_DW'(8'h1F);
      default:      impl_mask = {REG_DW{1'b1}};
    endcase
  endfunction
endpackage

// File: rtl/snd_addr_latch.sv
module snd_addr_latch
  import snd_bus_pkg::*;
#(
  parameter int DW = REG_DW,
  parameter int PW = PTR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          is_addr,
  input  logic [1:0]    hi_addr,
  input  logic [DW-1:0] din,
  output logic [PW-1:0] ptr,
  output logic          sel
);
  logic match;
  assign match = (hi_addr == 2'b01) && (din[DW-1:PW] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
      sel <= 1'b0;
    end else if (is_addr) begin
      sel <= match;
      if (match) ptr <= din[PW-1:0];
    end
  end
endmodule

// File: rtl/snd_reg_file.sv
module snd_reg_file
  import snd_bus_pkg::*;
#(
  parameter int DW   = REG_DW,
  parameter int NREG = REG_NUM,
  parameter int PW   = PTR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [PW-1:0]      waddr,
  input  logic [DW-1:0]      wdata,
  output logic [NREG*DW-1:0] regs_flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam logic [DW-1:0] MASK = impl_mask(g);
    logic [DW-1:0] r;
    always_ff @(posedge clk) begin
      if (rst)                              r <= '0;
      else if (we && (waddr == PW'(g)))     r <= wdata & MASK;
    end
    assign regs_flat[g*DW +: DW] = r;
  end
endmodule

// File: rtl/snd_port_io.sv
module snd_port_io #(
  parameter int DW = 8
) (
  input  logic          dir_out,
  input  logic [DW-1:0] reg_val,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] pin_out,
  output logic          pin_oe,
  output logic [DW-1:0] rd_val
);
  assign pin_out = reg_val;
  assign pin_oe  = dir_out;
  assign rd_val  = dir_out ? reg_val : pin_in;
endmodule

// File: rtl/snd_bus_if.sv
module snd_bus_if
  import snd_bus_pkg::*;
#(
  parameter int DW   = REG_DW,
  parameter int NREG = REG_NUM
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bdir,
  input  logic               bc2,
  input  logic               bc1,
  input  logic [1:0]         hi_addr,
  input  logic [DW-1:0]      data_in,
  output logic [DW-1:0]      data_out,
  output logic               data_oe,
  output logic [NREG*DW-1:0] reg_flat,
  output logic               env_restart,
  input  logic [DW-1:0]      porta_in,
  output logic [DW-1:0]      porta_out,
  output logic               porta_oe,
  input  logic [DW-1:0]      portb_in,
  output logic [DW-1:0]      portb_out,
  output logic               portb_oe
);
  localparam int PW = $clog2(NREG);

  bus_mode_e     mode;
  logic          is_addr, is_write, is_read;
  logic [PW-1:0] ptr_q;
  logic          sel_q;
  logic [DW-1:0] pa_rd, pb_rd, rd_word, ioctl;

  assign mode     = decode_mode({bdir, bc2, bc1});
  assign is_addr  = (mode == M_ADDR);
  assign is_write = (mode == M_WRITE) && sel_q;
  assign is_read  = (mode == M_READ) && sel_q;

  snd_addr_latch #(.DW(DW), .PW(PW)) u_latch (
    .clk(clk), .rst(rst), .is_addr(is_addr), .hi_addr(hi_addr),
    .din(data_in), .ptr(ptr_q), .sel(sel_q)
  );

  snd_reg_file #(.DW(DW), .NREG(NREG), .PW(PW)) u_regs (
    .clk(clk), .rst(rst), .we(is_write), .waddr(ptr_q),
    .wdata(data_in), .regs_flat(reg_flat)
  );

  assign ioctl = reg_flat[IOCTL_IDX*DW +: DW];

  snd_port_io #(.DW(DW)) u_port_a (
    .dir_out(ioctl[DIR_A_BIT]), .reg_val(reg_flat[PORTA_IDX*DW +: DW]),
    .pin_in(porta_in), .pin_out(porta_out), .pin_oe(porta_oe), .rd_val(pa_rd)
  );

  snd_port_io #(.DW(DW)) u_port_b (
    .dir_out(ioctl[DIR_B_BIT]), .reg_val(reg_flat[PORTB_IDX*DW +: DW]),
    .pin_in(portb_in), .pin_out(portb_out), .pin_oe(portb_oe), .rd_val(pb_rd)
  );

  always_comb begin
    if (ptr_q == PW'(PORTA_IDX))      rd_word = pa_rd;
    else if (ptr_q == PW'(PORTB_IDX)) rd_word = pb_rd;
    else                              rd_word = reg_flat[ptr_q*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out    <= '0;
      data_oe     <= 1'b0;
      env_restart <= 1'b0;
    end else begin
      data_oe     <= is_read;
      if (is_read) data_out <= rd_word;
      env_restart <= is_write && (ptr_q == PW'(ENV_IDX));
    end
  end
endmodule

// File: rtl/snd_bus_chk.sv
module snd_bus_chk
  import snd_bus_pkg::*;
(
  input logic                      clk,
  input logic                      rst,
  input logic [2:0]                code,
  input logic [PTR_W-1:0]          ptr,
  input logic                      data_oe,
  input logic                      env_restart,
  input logic [REG_NUM*REG_DW-1:0] reg_flat
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (reg_flat == '0 && !data_oe && !env_restart));

  // R8
  oe_after_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> $past(code == 3'b011));

  // R9
  env_after_store_chk: assert property (@(posedge clk) disable iff (rst)
    env_restart |-> $past(code == 3'b110 && ptr == PTR_W'(ENV_IDX)));

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(code inside {3'b001, 3'b100, 3'b111}) |=> $stable(ptr));

  // R7
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_flat[15:12] == '0) && (reg_flat[31:28] == '0) &&
    (reg_flat[47:44] == '0) && (reg_flat[55:53] == '0) &&
    (reg_flat[71:69] == '0) && (reg_flat[79:77] == '0) &&
    (reg_flat[87:85] == '0) && (reg_flat[111:108] == '0));
endmodule

bind snd_bus_if snd_bus_chk u_chk (
  .clk(clk), .rst(rst), .code({bdir, bc2, bc1}), .ptr(ptr_q),
  .data_oe(data_oe), .env_restart(env_restart), .reg_flat(reg_flat)
);

// File: tb/tb_snd_bus_if.sv
module tb_snd_bus_if;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bdir = 0, bc2 = 0, bc1 = 0;
  logic [1:0]   hi_addr = 2'b01;
  logic [7:0]   data_in = 0, porta_in = 0, portb_in = 0;
  logic [7:0]   data_out, porta_out, portb_out;
  logic         data_oe, env_restart, porta_oe, portb_oe;
  logic [127:0] reg_flat;

  int checks = 0, errors = 0;

  logic [7:0] m_reg [16];
  logic [3:0] m_ptr;
  logic       m_sel;

  always #2.5 clk = ~clk;

  snd_bus_if dut (
    .clk(clk), .rst(rst), .bdir(bdir), .bc2(bc2), .bc1(bc1), .hi_addr(hi_addr),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe), .reg_flat(reg_flat),
    .env_restart(env_restart), .porta_in(porta_in), .porta_out(porta_out),
    .porta_oe(porta_oe), .portb_in(portb_in), .portb_out(portb_out), .portb_oe(portb_oe)
  );

  function automatic logic [7:0] mask_of(input int i);
    if (i == 1 || i == 3 || i == 5 || i == 13) return 8'h0F;
    if (i == 6 || i == 8 || i == 9 || i == 10) return 8'h1F;
    return 8'hFF;
  endfunction

  function automatic logic [127:0] model_flat();
    logic [127:0] f;
    for (int i = 0; i < 16; i++) f[i*8 +: 8] = m_reg[i];
    return f;
  endfunction

  function automatic logic [7:0] model_read(input logic [3:0] p);
    if (p == 4'd14) return m_reg[7][6] ? m_reg[14] : porta_in;
    if (p == 4'd15) return m_reg[7][7] ? m_reg[15] : portb_in;
    return m_reg[p];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
    m_ptr = 4'd0;
    m_sel = 1'b0;
  endtask

  // One bus cycle; called at a falling edge, returns at the next falling edge.
  task automatic step(input logic [2:0] code, input logic [1:0] hi,
                      input logic [7:0] d, input string req);
    logic       e_oe, e_env;
    logic [7:0] e_out;
    {bdir, bc2, bc1} = code;
    hi_addr = hi;
    data_in = d;
    e_oe = 1'b0; e_env = 1'b0; e_out = 8'h00;
    case (code)
      3'b001, 3'b100, 3'b111: begin
        if (hi == 2'b01 && d[7:4] == 4'h0) begin m_ptr = d[3:0]; m_sel = 1'b1; end
        else m_sel = 1'b0;
      end
      3'b110: if (m_sel) begin
        m_reg[m_ptr] = d & mask_of(int'(m_ptr));
        e_env = (m_ptr == 4'd13);
      end
      3'b011: if (m_sel) begin e_oe = 1'b1; e_out = model_read(m_ptr); end
      default: ;
    endcase
    @(negedge clk);
    chk(data_oe === e_oe, req, "data_oe", 128'(data_oe), 128'(e_oe));
    if (e_oe) chk(data_out === e_out, req, "data_out", 128'(data_out), 128'(e_out));
    chk(env_restart === e_env, req, "env_restart", 128'(env_restart), 128'(e_env));
    chk(reg_flat === model_flat(), req, "reg_flat", reg_flat, model_flat());
    chk(porta_oe === m_reg[7][6] && portb_oe === m_reg[7][7] &&
        porta_out === m_reg[14] && portb_out === m_reg[15], req, "ports",
        128'({porta_oe, portb_oe, porta_out, portb_out}),
        128'({m_reg[7][6], m_reg[7][7], m_reg[14], m_reg[15]}));
  endtask

  task automatic do_reset(input string req);
    rst = 1'b1;
    {bdir, bc2, bc1} = 3'b000;
    @(negedge clk);
    @(negedge clk);
    model_reset();
    chk(reg_flat === '0, req, "reg_flat after reset", reg_flat, '0);
    chk(data_oe === 1'b0 && env_restart === 1'b0, req, "oe/env after reset",
        128'({data_oe, env_restart}), 128'(0));
    rst = 1'b0;
  endtask

  initial begin
    logic [2:0] addr_codes [3];
    addr_codes[0] = 3'b001; addr_codes[1] = 3'b100; addr_codes[2] = 3'b111;
    void'($urandom(32'd2749));
    model_reset();
    @(negedge clk);
    do_reset("R1");
    // R1: deselected after reset, fetch does not drive the bus
    step(3'b011, 2'b01, 8'h00, "R1");

    // R2 R3 R6 R7: store every register through each pointer-load code
    for (int i = 0; i < 16; i++) begin
      step(addr_codes[i % 3], 2'b01, 8'(i), "R3");
      step(3'b110, 2'b01, 8'($urandom), "R6");
    end
    for (int i = 0; i < 16; i++) begin
      step(3'b001, 2'b01, 8'(i), "R3");
      step(3'b110, 2'b01, 8'hFF, "R7");
      step(3'b011, 2'b01, 8'h00, "R8");
    end

    // R2: idle codes change nothing
    step(3'b000, 2'b01, 8'h05, "R2");
    step(3'b010, 2'b01, 8'hA5, "R2");
    step(3'b101, 2'b01, 8'h5A, "R2");

    // R4: mismatching upper address deselects and keeps the pointer
    step(3'b001, 2'b01, 8'h02, "R4");
    step(3'b100, 2'b00, 8'h03, "R4");
    step(3'b011, 2'b01, 8'h00, "R4");
    step(3'b110, 2'b01, 8'h77, "R4");
    step(3'b111, 2'b01, 8'h13, "R4");
    step(3'b110, 2'b01, 8'h66, "R4");
    step(3'b001, 2'b11, 8'h04, "R4");
    step(3'b011, 2'b01, 8'h00, "R4");
    step(3'b001, 2'b01, 8'h02, "R4");
    step(3'b011, 2'b01, 8'h00, "R4");

    // R5: pointer persists across other cycles
    step(3'b001, 2'b01, 8'h05, "R5");
    step(3'b110, 2'b01, 8'h3C, "R5");
    step(3'b000, 2'b01, 8'h0A, "R5");
    step(3'b011, 2'b01, 8'h00, "R5");
    step(3'b110, 2'b01, 8'h0B, "R5");
    step(3'b010, 2'b01, 8'h01, "R5");
    step(3'b011, 2'b01, 8'h00, "R5");

    // R9: restart pulse only for register 13 stores
    step(3'b001, 2'b01, 8'h0D, "R9");
    step(3'b110, 2'b01, 8'hFE, "R9");
    step(3'b011, 2'b01, 8'h00, "R9");
    step(3'b000, 2'b01, 8'h00, "R9");
    step(3'b001, 2'b01, 8'h0C, "R9");
    step(3'b110, 2'b01, 8'h0D, "R9");

    // R10 R11: port directions and fetch sources
    porta_in = 8'hC3; portb_in = 8'h3C;
    step(3'b001, 2'b01, 8'h0E, "R10");
    step(3'b110, 2'b01, 8'h11, "R10");
    step(3'b001, 2'b01, 8'h0F, "R10");
    step(3'b110, 2'b01, 8'h22, "R10");
    for (int m = 0; m < 4; m++) begin
      step(3'b001, 2'b01, 8'h07, "R10");
      step(3'b110, 2'b01, {2'(m), 6'h00}, "R10");
      step(3'b001, 2'b01, 8'h0E, "R11");
      step(3'b011, 2'b01, 8'h00, "R11");
      step(3'b001, 2'b01, 8'h0F, "R11");
      step(3'b011, 2'b01, 8'h00, "R11");
    end

    // Random mix covering R2..R11
    for (int n = 0; n < 600; n++) begin
      logic [7:0] d;
      logic [1:0] hi;
      porta_in = 8'($urandom);
      portb_in = 8'($urandom);
      d  = 8'($urandom);
      if ($urandom % 10 < 7) d[7:4] = 4'h0;
      hi = ($urandom % 4 == 0) ? 2'($urandom) : 2'b01;
      step(3'($urandom), hi, d, "R2");
    end

    // R1: reset in mid-run clears everything
    do_reset("R1");
    step(3'b011, 2'b01, 8'h00, "R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule